// File: doc/BRIEF.md
# Sliding-Window Register File

This block is a large general-purpose register store of which an instruction can address only a 32-entry slice at a time. A base register selects the physical index of the slice's first entry. Every 5-bit register specifier that reaches the block is taken as an offset and added to that base. The sum is the physical entry that is read or written.

A call request raises the base by 16 and a return request lowers it by 16. Because the step is half the window, the upper 16 entries of a caller's window are the lower 16 entries of the callee's window. Arguments and results pass through these shared entries. A move that would push the window past either end of the store is refused: the base keeps its value and an exception flag is raised for one cycle.

The block has two combinational read ports and one write port that updates on the clock edge. The exception handler, instruction decode and datapath sit outside the block.

Top module: `sliding_window_rf`

## Requirements
- R1: After reset the base (`win_base_o`) is 0 and `win_exc_o` is low.
- R2: Each read port returns, without a clock edge, the entry at physical index base + offset. The two ports are independent.
- R3: A call request (`call_i`=1, `ret_i`=0) with base <= 976 sets the base to base + 16 at the next edge.
- R4: A return request (`ret_i`=1, `call_i`=0) with base >= 16 sets the base to base - 16 at the next edge.
- R5: A call with base > 976, or a return with base < 16, leaves the base unchanged. `win_exc_o` is high for exactly the one cycle after the edge that sampled that request.
- R6: When `call_i` and `ret_i` are both high, the base does not move and no exception is raised.
- R7: When `wr_en_i`=1, `wr_data_i` is stored at base + `wr_off_i` at the clock edge. If a move happens in the same cycle, the write uses the base from before the move.
- R8: A read of the entry being written in the same cycle returns the value stored before the write.
- R9: Offsets 16..31 of a window are the same physical entries as offsets 0..15 of the window one call deeper.
- R10: The base is always a multiple of 16 and never exceeds 992, so every physical index stays within 0..1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Request to move the window up by 16 |
| ret_i | input | 1 | Request to move the window down by 16 |
| rd_a_off_i | input | 5 | Read port A offset within the window |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_off_i | input | 5 | Read port B offset within the window |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_off_i | input | 5 | Write offset within the window |
| wr_data_i | input | 32 | Write data |
| win_base_o | output | 10 | Current window base (physical index) |
| win_exc_o | output | 1 | One-cycle pulse after a refused move |

## Verification
The embedded assertions check on every cycle the rules of the base register: the step size after a legal call or return, the base holding on a refused or conflicting move, the base staying aligned and in range, and a written entry holding the written data. They also check that the exception flag only follows a move request. Only the bench's scenarios can show the address mapping seen through the read ports. This covers the sharing of entries between caller and callee windows, the old-base rule for a write combined with a move, and the old value returned when a read and a write hit the same entry in one cycle. The bench also walks the window to the top of the store, so the refusal at the upper limit is shown there.

// File: rtl/swrf_pkg.sv
package swrf_pkg;
  localparam int unsigned NUM_REGS = 1024;
  localparam int unsigned WIN_REGS = 32;
  localparam int unsigned STEP     = WIN_REGS / 2;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned OFF_W    = $clog2(WIN_REGS);
  localparam int unsigned MAX_BASE = NUM_REGS - WIN_REGS;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'b00,
    MOVE_UP   = 2'b01,
    MOVE_DOWN = 2'b10
  } move_e;
endpackage

// File: rtl/swrf_base_ctrl.sv
module swrf_base_ctrl
  import swrf_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_REGS,
  parameter int unsigned W_REGS = WIN_REGS,
  parameter int unsigned I_W    = IDX_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           call_i,
  input  logic           ret_i,
  output logic [I_W-1:0] base_o,
  output logic           exc_o
);
  localparam int unsigned S_STEP = W_REGS / 2;
  localparam int unsigned TOP    = N_REGS - W_REGS;
  localparam logic [I_W-1:0] STEP_V    = I_W'(S_STEP);
  localparam logic [I_W-1:0] UP_LIMIT  = I_W'(TOP - S_STEP);
  localparam logic [I_W-1:0] TOP_V     = I_W'(TOP);

  logic [I_W-1:0] base_q, base_d;
  logic           exc_q, exc_d;
  move_e          move;
  logic           up_ok, down_ok;

  always_comb begin
    unique case ({ret_i, call_i})
      2'b01:   move = MOVE_UP;
      2'b10:   move = MOVE_DOWN;
      default: move = MOVE_NONE;  // idle or conflicting request
    endcase
  end

  assign up_ok   = (base_q <= UP_LIMIT);
  assign down_ok = (base_q >= STEP_V);

  always_comb begin
    base_d = base_q;
    exc_d  = 1'b0;
    case (move)
      MOVE_UP:   if (up_ok)   base_d = base_q + STEP_V; else exc_d = 1'b1;
      MOVE_DOWN: if (down_ok) base_d = base_q - STEP_V; else exc_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      exc_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      exc_q  <= exc_d;
    end
  end

  assign base_o = base_q;
  assign exc_o  = exc_q;

  p_call_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && base_o <= UP_LIMIT) |=> (base_o == $past(base_o) + STEP_V));

  p_ret_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && base_o >= STEP_V) |=> (base_o == $past(base_o) - STEP_V));

  p_refused_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((call_i && !ret_i && base_o > UP_LIMIT) || (ret_i && !call_i && base_o < STEP_V))
      |=> ($stable(base_o) && exc_o));

  p_exc_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_o) |-> $past(call_i ^ ret_i));

  p_conflict_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i) |=> ($stable(base_o) && !exc_o));

  p_base_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_o <= TOP_V) && (base_o % STEP_V == '0));
endmodule

// File: rtl/swrf_addr_xlate.sv
module swrf_addr_xlate
  import swrf_pkg::*;
#(
  parameter int unsigned I_W = IDX_W,
  parameter int unsigned O_W = OFF_W
) (
  input  logic [I_W-1:0] base_i,
  input  logic [O_W-1:0] off_i,
  output logic [I_W-1:0] idx_o
);
  // base is capped so the sum never wraps
  assign idx_o = base_i + I_W'(off_i);
endmodule

// File: rtl/swrf_storage.sv
module swrf_storage
  import swrf_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_REGS,
  parameter int unsigned D_W    = DATA_W,
  parameter int unsigned I_W    = IDX_W,
  parameter int unsigned N_RD   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_RD-1:0][I_W-1:0] rd_idx_i,
  output logic [N_RD-1:0][D_W-1:0] rd_data_o,
  input  logic                     wr_en_i,
  input  logic [I_W-1:0]           wr_idx_i,
  input  logic [D_W-1:0]           wr_data_i
);
  logic [D_W-1:0] mem_q [N_REGS];

  // storage carries no reset; contents are undefined until written
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_idx_i[p]];
  end

  p_write_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem_q[$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/sliding_window_rf.sv
module sliding_window_rf
  import swrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [OFF_W-1:0]  rd_a_off_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [OFF_W-1:0]  rd_b_off_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [IDX_W-1:0]  win_base_o,
  output logic              win_exc_o
);
  localparam int unsigned N_RD = 2;

  logic [IDX_W-1:0]                base;
  logic [N_RD-1:0][OFF_W-1:0]      rd_off;
  logic [N_RD-1:0][IDX_W-1:0]      rd_idx;
  logic [N_RD-1:0][DATA_W-1:0]     rd_data;
  logic [IDX_W-1:0]                wr_idx;

  swrf_base_ctrl u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .call_i (call_i),
    .ret_i  (ret_i),
    .base_o (base),
    .exc_o  (win_exc_o)
  );

  assign rd_off[0] = rd_a_off_i;
  assign rd_off[1] = rd_b_off_i;

  for (genvar p = 0; p < N_RD; p++) begin : g_rd_xlate
    swrf_addr_xlate u_xl (
      .base_i (base),
      .off_i  (rd_off[p]),
      .idx_o  (rd_idx[p])
    );
  end

  // write uses the current (pre-move) base
  swrf_addr_xlate u_wr_xl (
    .base_i (base),
    .off_i  (wr_off_i),
    .idx_o  (wr_idx)
  );

  swrf_storage #(.N_RD(N_RD)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data_i)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign win_base_o  = base;
endmodule

// File: tb/sliding_window_rf_tb.sv
`timescale 1ns/1ps
module sliding_window_rf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call = 1'b0, ret = 1'b0;
  logic [4:0]  ra = '0, rb = '0, wo = '0;
  logic [31:0] rda, rdb, wd = '0;
  logic        we = 1'b0;
  logic [9:0]  base;
  logic        exc;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sliding_window_rf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret),
    .rd_a_off_i(ra), .rd_a_data_o(rda), .rd_b_off_i(rb), .rd_b_data_o(rdb),
    .wr_en_i(we), .wr_off_i(wo), .wr_data_i(wd),
    .win_base_o(base), .win_exc_o(exc)
  );

  // {call, ret, expected base, expected exc}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 1'b1, 10'd0,  1'b1},  // R5 return at floor
    {1'b1, 1'b0, 10'd16, 1'b0},  // R3
    {1'b1, 1'b0, 10'd32, 1'b0},  // R3
    {1'b1, 1'b1, 10'd32, 1'b0},  // R6 conflict
    {1'b0, 1'b1, 10'd16, 1'b0},  // R4
    {1'b0, 1'b1, 10'd0,  1'b0},  // R4
    {1'b0, 1'b1, 10'd0,  1'b1},  // R5
    {1'b1, 1'b0, 10'd16, 1'b0}   // R3
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock edge; inputs change 1 ns after it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    call = 1'b0; ret = 1'b0; we = 1'b0;
  endtask

  task automatic do_write(logic [4:0] off, logic [31:0] val);
    we = 1'b1; wo = off; wd = val;
    tick();
    idle();
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #7 rst_n = 1'b1;
    #1;
    chk("R1 base", 32'(base), 32'd0);
    chk("R1 exc", 32'(exc), 32'd0);

    for (int i = 0; i < 8; i++) begin
      call = VEC[i][12]; ret = VEC[i][11];
      tick();
      idle();
      chk($sformatf("R3/R4/R5/R6 vec%0d base", i), 32'(base), 32'(VEC[i][10:1]));
      chk($sformatf("R5 vec%0d exc", i), 32'(exc), 32'(VEC[i][0]));
    end
    tick();
    chk("R5 exc single cycle", 32'(exc), 32'd0);

    // back to base 0
    ret = 1'b1; tick(); idle();
    chk("R4 base", 32'(base), 32'd0);

    // R2: two independent read ports
    do_write(5'd3, 32'hA0A0_0003);
    do_write(5'd20, 32'hC0DE_0020);
    ra = 5'd3; rb = 5'd20; #1;
    chk("R2 port a", rda, 32'hA0A0_0003);
    chk("R2 port b", rdb, 32'hC0DE_0020);

    // R8: same-cycle read of written entry gives old value
    we = 1'b1; wo = 5'd3; wd = 32'h1111_2222; ra = 5'd3; #1;
    chk("R8 old value", rda, 32'hA0A0_0003);
    tick(); idle();
    chk("R8 new value after edge", rda, 32'h1111_2222);

    // R9: caller offset 20 is callee offset 4
    call = 1'b1; tick(); idle();
    ra = 5'd4; #1;
    chk("R9 shared entry", rda, 32'hC0DE_0020);
    chk("R2 offset on base 16", 32'(base), 32'd16);

    // R7: write with move uses old base (index 17, not 33)
    do_write(5'd17, 32'h0);         // base 16 -> index 33 cleared
    we = 1'b1; wo = 5'd1; wd = 32'hBEEF_0017; call = 1'b1;
    tick(); idle();
    chk("R7 base moved", 32'(base), 32'd32);
    ra = 5'd1; #1;
    chk("R7 new base entry untouched", rda, 32'h0);
    ret = 1'b1; tick(); idle();
    ra = 5'd1; #1;
    chk("R7 write at old base", rda, 32'hBEEF_0017);

    // R10 / R5: climb to the top of the store
    for (int k = 0; k < 61; k++) begin
      call = 1'b1; tick();
    end
    idle();
    chk("R10 top base", 32'(base), 32'd992);
    chk("R10 no exc on last legal call", 32'(exc), 32'd0);
    do_write(5'd31, 32'hFEED_03FF);
    ra = 5'd31; #1;
    chk("R10 last physical entry", rda, 32'hFEED_03FF);
    call = 1'b1; tick(); idle();
    chk("R5 refused call base", 32'(base), 32'd992);
    chk("R5 refused call exc", 32'(exc), 32'd1);
    tick();
    chk("R5 exc drops", 32'(exc), 32'd0);

    // R1: reset mid-run
    rst_n = 1'b0; #3;
    chk("R1 base on reset", 32'(base), 32'd0);
    chk("R1 exc on reset", 32'(exc), 32'd0);
    rst_n = 1'b1;
    tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule